// File: doc/BRIEF.md
# Flash Toggle-Status Poller

This block runs on the host side and decides when a flash program or erase operation has finished. It does not read a ready flag. Instead it reads the device's status word at a target address twice in a row and compares the two reads. The main toggle bit (bit 6) toggles on every read while an embedded operation is running. A second toggle bit (bit 2) toggles only when the read address lies in a sector that has been selected for erase. Bit 5 reports that the device's internal time limit has been exceeded.

The controller is started by a single-cycle pulse that carries the address to poll. It then issues pairs of read requests over a valid/ready request channel and takes the data back over a valid/ready response channel. A programmable number of idle cycles sits between consecutive reads. When polling ends it reports exactly one outcome: done, failed, timed out, or erase-suspended. It also reports whether the polled sector was actively erasing in the last read pair. It then stays idle until the next start.

Back-pressure rules:
- A read request, once raised, holds its valid and its address until the cycle in which ready is high.
- The response channel is ready only while a read is outstanding.
- At most one read is in flight at a time.

Top module: `tbp_toggle_poller`

## Requirements
- R1: After reset the block is idle: busy, all four outcome flags, sector_erasing and rd_req_valid are low.
- R2: A start pulse while idle captures target_addr, gap_cycles and max_polls and begins polling; every read request carries the captured address. A start pulse while busy has no effect on the address or on the outcome.
- R3: rd_req_valid, once high, stays high with rd_req_addr unchanged until rd_req_ready is high. rsp_ready is high only while a read is outstanding, and no new request is raised while rsp_ready is high.
- R4: After each accepted response that does not end polling, rd_req_valid stays low for exactly gap_cycles+1 cycles before the next request.
- R5: Reads are evaluated in pairs. If bit 6 and bit 2 are both equal across the pair, polling ends with done.
- R6: If bit 6 is equal but bit 2 differs across the pair, polling ends with suspended (the polled sector is erase-suspended).
- R7: If bit 6 differs and bit 5 of the second read is low, one poll is counted and a new pair is read.
- R8: If bit 6 differs and bit 5 of the second read is high, exactly one further pair is read as a recheck. If bit 6 is steady in that recheck pair, it is classified by R5/R6.
- R9: If bit 6 still differs in the recheck pair, polling ends with failed.
- R10: When the count of R7 pairs reaches max_polls (a value of 0 acts as 1), polling ends with timed_out.
- R11: sector_erasing is high after a pair exactly when both bit 6 and bit 2 differed in that pair. It is cleared on start.
- R12: While busy all outcome flags are low. After polling ends exactly one of them is high, and it stays high until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, honoured only while idle |
| target_addr | input | AW | Address to poll |
| gap_cycles | input | GW | Idle cycles inserted between reads |
| max_polls | input | CW | Poll limit before timeout |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | AW | Read request address |
| rsp_valid | input | 1 | Read data valid |
| rsp_ready | output | 1 | Ready for read data |
| rsp_data | input | DW | Status word returned by the read |
| busy | output | 1 | Polling in progress |
| done | output | 1 | Operation completed |
| failed | output | 1 | Toggling persisted after bit 5 rose |
| timed_out | output | 1 | Poll limit reached |
| suspended | output | 1 | Polled sector is erase-suspended |
| sector_erasing | output | 1 | Polled sector actively erasing in the last pair |

## Verification
The assertions assume three things about the inputs. gap_cycles holds its value while busy. A response arrives only after a request has been accepted. rsp_valid is never raised while rsp_ready is low in a way that would skip a read. The bench keeps within these limits in the following ways. Its responder raises rsp_valid only for a request it has seen accepted. gap_cycles is changed only between runs. The request ready and response timing are varied by cycle pattern, so that back-pressure occurs on both channels.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GAP  = 2'd1,
    ST_REQ  = 2'd2,
    ST_RSP  = 2'd3
  } tbp_state_e;
endpackage

// File: rtl/tbp_gap_timer.sv
module tbp_gap_timer #(
  parameter int GW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [GW-1:0] load_val,
  output logic          expired
);
  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/tbp_toggle_eval.sv
module tbp_toggle_eval #(
  parameter int DW       = 8,
  parameter int BIT_TOG  = 6,
  parameter int BIT_SEL  = 2,
  parameter int BIT_LIM  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [DW-1:0] sample,
  output logic          tog_main,
  output logic          tog_sel,
  output logic          lim_bit
);
  localparam int NB = 2;
  logic [NB-1:0] first_q;
  logic [NB-1:0] now_bits;

  assign now_bits = {sample[BIT_TOG], sample[BIT_SEL]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       first_q <= '0;
    else if (capture) first_q <= now_bits;
  end

  assign tog_main = first_q[1] ^ now_bits[1];
  assign tog_sel  = first_q[0] ^ now_bits[0];
  assign lim_bit  = sample[BIT_LIM];
endmodule

// File: rtl/tbp_poll_fsm.sv
module tbp_poll_fsm
  import tbp_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] max_q,
  input  logic          gap_done,
  input  logic          req_ready,
  input  logic          rsp_valid,
  input  logic          tog_main,
  input  logic          tog_sel,
  input  logic          lim_bit,
  output logic          start_acc,
  output logic          rsp_hs,
  output logic          first_hs,
  output logic          req_valid,
  output logic          rsp_ready,
  output logic          busy,
  output logic          done,
  output logic          failed,
  output logic          timed_out,
  output logic          suspended,
  output logic          sector_erasing
);
  tbp_state_e    state_q;
  logic          second_q;
  logic          recheck_q;
  logic [CW-1:0] polls_q;
  logic [CW:0]   polls_next;

  assign busy       = (state_q != ST_IDLE);
  assign req_valid  = (state_q == ST_REQ);
  assign rsp_ready  = (state_q == ST_RSP);
  assign start_acc  = start && (state_q == ST_IDLE);
  assign rsp_hs     = rsp_ready && rsp_valid;
  assign first_hs   = rsp_hs && !second_q;
  assign polls_next = {1'b0, polls_q} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q        <= ST_IDLE;
      second_q       <= 1'b0;
      recheck_q      <= 1'b0;
      polls_q        <= '0;
      done           <= 1'b0;
      failed         <= 1'b0;
      timed_out      <= 1'b0;
      suspended      <= 1'b0;
      sector_erasing <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          state_q        <= ST_GAP;
          second_q       <= 1'b0;
          recheck_q      <= 1'b0;
          polls_q        <= '0;
          done           <= 1'b0;
          failed         <= 1'b0;
          timed_out      <= 1'b0;
          suspended      <= 1'b0;
          sector_erasing <= 1'b0;
        end
        ST_GAP: if (gap_done) state_q <= ST_REQ;
        ST_REQ: if (req_ready) state_q <= ST_RSP;
        ST_RSP: if (rsp_valid) begin
          if (!second_q) begin
            second_q <= 1'b1;
            state_q  <= ST_GAP;
          end else begin
            second_q       <= 1'b0;
            sector_erasing <= tog_main & tog_sel;
            if (!tog_main) begin
              state_q <= ST_IDLE;
              if (tog_sel) suspended <= 1'b1;
              else         done      <= 1'b1;
            end else if (recheck_q) begin
              state_q <= ST_IDLE;
              failed  <= 1'b1;
            end else if (lim_bit) begin
              recheck_q <= 1'b1;
              state_q   <= ST_GAP;
            end else if (polls_next >= {1'b0, max_q}) begin
              state_q   <= ST_IDLE;
              timed_out <= 1'b1;
            end else begin
              polls_q <= polls_next[CW-1:0];
              state_q <= ST_GAP;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tbp_toggle_poller.sv
module tbp_toggle_poller #(
  parameter int AW      = 20,
  parameter int DW      = 8,
  parameter int GW      = 4,
  parameter int CW      = 16,
  parameter int BIT_TOG = 6,
  parameter int BIT_SEL = 2,
  parameter int BIT_LIM = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] target_addr,
  input  logic [GW-1:0] gap_cycles,
  input  logic [CW-1:0] max_polls,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_req_addr,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [DW-1:0] rsp_data,
  output logic          busy,
  output logic          done,
  output logic          failed,
  output logic          timed_out,
  output logic          suspended,
  output logic          sector_erasing
);
  logic [AW-1:0] addr_q;
  logic [GW-1:0] gap_q;
  logic [CW-1:0] max_q;
  logic          start_acc, rsp_hs, first_hs, gap_done;
  logic          tog_main, tog_sel, lim_bit;
  logic          tmr_load;
  logic [GW-1:0] tmr_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      gap_q  <= '0;
      max_q  <= '0;
    end else if (start_acc) begin
      addr_q <= target_addr;
      gap_q  <= gap_cycles;
      max_q  <= max_polls;
    end
  end

  assign rd_req_addr = addr_q;
  assign tmr_load    = start_acc | rsp_hs;
  assign tmr_val     = start_acc ? '0 : gap_q;

  tbp_gap_timer #(.GW(GW)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(gap_done)
  );

  tbp_toggle_eval #(
    .DW(DW), .BIT_TOG(BIT_TOG), .BIT_SEL(BIT_SEL), .BIT_LIM(BIT_LIM)
  ) u_eval (
    .clk(clk), .rst_n(rst_n), .capture(first_hs), .sample(rsp_data),
    .tog_main(tog_main), .tog_sel(tog_sel), .lim_bit(lim_bit)
  );

  tbp_poll_fsm #(.CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .max_q(max_q),
    .gap_done(gap_done), .req_ready(rd_req_ready), .rsp_valid(rsp_valid),
    .tog_main(tog_main), .tog_sel(tog_sel), .lim_bit(lim_bit),
    .start_acc(start_acc), .rsp_hs(rsp_hs), .first_hs(first_hs),
    .req_valid(rd_req_valid), .rsp_ready(rsp_ready), .busy(busy),
    .done(done), .failed(failed), .timed_out(timed_out),
    .suspended(suspended), .sector_erasing(sector_erasing)
  );
endmodule

// File: rtl/tbp_toggle_poller_chk.sv
module tbp_toggle_poller_chk #(
  parameter int AW = 20,
  parameter int GW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [GW-1:0] gap_cycles,
  input logic          rd_req_valid,
  input logic          rd_req_ready,
  input logic [AW-1:0] rd_req_addr,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic          busy,
  input logic          done,
  input logic          failed,
  input logic          timed_out,
  input logic          suspended,
  input logic          sector_erasing
);
  logic [GW:0] idle_cnt;
  logic        armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      armed    <= 1'b0;
    end else if (start && !busy) begin
      armed <= 1'b0;
    end else if (rsp_valid && rsp_ready) begin
      armed    <= 1'b1;
      idle_cnt <= '0;
    end else if (rd_req_valid) begin
      armed <= 1'b0;
    end else if (armed && idle_cnt != {(GW+1){1'b1}}) begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req_valid && !rsp_ready);

  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  a_r3_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> !rd_req_valid);

  a_r2_start_begins: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  a_r4_gap_exact: assert property (@(posedge clk) disable iff (!rst_n)
    armed && rd_req_valid |-> idle_cnt == {1'b0, gap_cycles} + 1'b1);

  a_r12_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, failed, timed_out, suspended}));

  a_r12_clear_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(done || failed || timed_out || suspended));

  a_r11_erasing_only_active: assert property (@(posedge clk) disable iff (!rst_n)
    sector_erasing && !busy |-> !done && !suspended);
endmodule

bind tbp_toggle_poller tbp_toggle_poller_chk #(.AW(AW), .GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .gap_cycles(gap_cycles),
  .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
  .rd_req_addr(rd_req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .busy(busy), .done(done), .failed(failed), .timed_out(timed_out),
  .suspended(suspended), .sector_erasing(sector_erasing)
);

// File: tb/tbp_toggle_poller_tb.sv
module tbp_toggle_poller_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int DW = 8;
  localparam int GW = 4;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] target_addr = '0;
  logic [GW-1:0] gap_cycles = '0;
  logic [CW-1:0] max_polls = '0;
  logic          rd_req_valid, rd_req_ready;
  logic [AW-1:0] rd_req_addr;
  logic          rsp_valid, rsp_ready;
  logic [DW-1:0] rsp_data;
  logic          busy, done, failed, timed_out, suspended, sector_erasing;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  logic [DW-1:0] script [16];
  int  idx = 0;
  bit  pend = 1'b0;
  bit  running = 1'b0;
  int  gap_seen = 0;
  bit  gap_armed = 1'b0;
  logic [AW-1:0] exp_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    rd_req_ready = 1'b0;
    rsp_valid    = 1'b0;
    rsp_data     = '0;
  end

  tbp_toggle_poller #(.AW(AW), .DW(DW), .GW(GW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .target_addr(target_addr),
    .gap_cycles(gap_cycles), .max_polls(max_polls),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .busy(busy), .done(done), .failed(failed),
    .timed_out(timed_out), .suspended(suspended),
    .sector_erasing(sector_erasing)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] scr(input int i);
    return (i < 16) ? script[i] : '0;
  endfunction

  // responder and per-clock comparisons
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (running) begin
        if (rd_req_valid) begin
          check("R2 addr", rd_req_addr, exp_addr);
          if (gap_armed) begin
            check("R4 gap", gap_seen, gap_cycles + 1);
            gap_armed = 1'b0;
          end
        end else if (gap_armed) gap_seen++;
        if (busy) check("R12 clear while busy",
                        {done, failed, timed_out, suspended}, 4'b0000);
      end
      rd_req_ready = (cyc % 3) != 1;
      rsp_valid    = pend && ((cyc % 2) == 0);
      rsp_data     = scr(idx);
      #1;
      if (rsp_valid && rsp_ready) begin
        pend = 1'b0;
        idx++;
        gap_armed = 1'b1;
        gap_seen  = 0;
      end
      if (rd_req_valid && rd_req_ready) pend = 1'b1;
    end
  end

  // behavioural reference: outcome 1 done, 2 failed, 3 timeout, 4 suspended
  task automatic model(input int maxp, output int res, output int nreads, output bit er);
    int i = 0;
    int polls = 0;
    bit rech = 1'b0;
    res = 0;
    er = 1'b0;
    while (res == 0) begin
      logic [DW-1:0] a, b;
      bit t6, t2;
      a = scr(i); b = scr(i + 1); i += 2;
      t6 = a[6] ^ b[6]; t2 = a[2] ^ b[2];
      er = t6 & t2;
      if (!t6) res = t2 ? 4 : 1;
      else if (rech) res = 2;
      else if (b[5]) rech = 1'b1;
      else begin
        polls++;
        if (polls >= ((maxp == 0) ? 1 : maxp)) res = 3;
      end
    end
    nreads = i;
  endtask

  task automatic run(input string tag, input logic [AW-1:0] addr, input int gap,
                     input int maxp, input bit poke);
    int res, nreads;
    bit er;
    logic [3:0] exp_flags;
    model(maxp, res, nreads, er);
    exp_flags = (res == 1) ? 4'b1000 : (res == 2) ? 4'b0100 :
                (res == 3) ? 4'b0010 : 4'b0001;
    @(negedge clk);
    idx = 0;
    gap_armed = 1'b0;
    target_addr = addr;
    gap_cycles  = gap[GW-1:0];
    max_polls   = maxp[CW-1:0];
    exp_addr    = addr;
    start = 1'b1;
    running = 1'b1;
    @(negedge clk);
    start = 1'b0;
    target_addr = ~addr;
    max_polls = '0;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1;       // R2: ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    running = 1'b0;
    check({tag, " outcome"}, {done, failed, timed_out, suspended}, exp_flags);
    check({tag, " reads"}, idx, nreads);
    check({tag, " R11 erasing"}, sector_erasing, er);
    repeat (4) @(negedge clk);
    check({tag, " R12 held"}, {done, failed, timed_out, suspended}, exp_flags);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    foreach (script[i]) script[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 reset", {busy, done, failed, timed_out, suspended, sector_erasing, rd_req_valid}, 7'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle", {busy, rd_req_valid, rsp_ready}, 3'b000);

    // R5: steady pair
    script[0] = 8'h40; script[1] = 8'h40;
    run("R5 done", 20'h01234, 0, 8, 1'b0);
    // R7 then R5: two toggling pairs with bit5 low, then steady
    script[0] = 8'h00; script[1] = 8'h40; script[2] = 8'h40; script[3] = 8'h00;
    script[4] = 8'h00; script[5] = 8'h00;
    run("R7 loop", 20'h0abcd, 3, 10, 1'b1);
    // R8: bit5 high, recheck steady -> done
    script[0] = 8'h00; script[1] = 8'h60; script[2] = 8'h20; script[3] = 8'h20;
    run("R8 recheck ok", 20'h00010, 1, 10, 1'b0);
    // R9: recheck still toggling -> failed
    script[0] = 8'h00; script[1] = 8'h60; script[2] = 8'h60; script[3] = 8'h20;
    run("R9 fail", 20'h00020, 2, 10, 1'b0);
    // R6: bit6 steady, bit2 toggles -> suspended
    script[0] = 8'h44; script[1] = 8'h40;
    run("R6 suspend", 20'h00030, 0, 10, 1'b0);
    // R8 with recheck landing on suspend
    script[0] = 8'h00; script[1] = 8'h60; script[2] = 8'h24; script[3] = 8'h20;
    run("R8 recheck susp", 20'h00031, 0, 10, 1'b0);
    // R10 and R11: single pair limit, both bits toggle
    script[0] = 8'h00; script[1] = 8'h44;
    run("R10 R11 timeout", 20'h00040, 0, 1, 1'b0);
    // R10: limit of two pairs
    script[0] = 8'h00; script[1] = 8'h40; script[2] = 8'h40; script[3] = 8'h00;
    script[4] = 8'h00; script[5] = 8'h00;
    run("R10 timeout2", 20'h00050, 4, 2, 1'b0);
    // R10: zero limit acts as one
    script[0] = 8'h04; script[1] = 8'h40;
    run("R10 zero", 20'h00060, 0, 0, 1'b0);
    // R11 cleared by a later steady pair
    script[0] = 8'h00; script[1] = 8'h44; script[2] = 8'h44; script[3] = 8'h44;
    run("R11 clear", 20'h00070, 1, 5, 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule